// File: doc/BRIEF.md
# Inter-core doorbell mailbox array

This block holds a bank of 32-bit mailboxes that cores use to signal one another. Each core owns four mailboxes, and there are sixteen in the default build. Each bit of a mailbox is an independent doorbell. A sender rings a doorbell by writing a word to the mailbox's set address: every 1 in that word turns the matching bit on. The receiving core reads the mailbox, picks a bit (usually the lowest one set) and writes that bit to the mailbox's clear address to acknowledge it. A core can also hand a complete 32-bit word to another core, such as a start address, by writing it into an empty mailbox.

Each mailbox drives one level interrupt line toward its owning core. The line stays high while any bit of that mailbox is set. Enabling and routing these lines is the job of a separate router, so this block does not do it. Access is through a simple register port with one write channel and one read channel. A read returns its data one cycle after the request.

Top module: `doorbell_mbox_array`

## Requirements
- R1: After reset every mailbox holds zero, every interrupt line is low, and rd_valid is low.
- R2: A write to a set address updates the mailbox to the bitwise OR of its old value and the written word.
- R3: A write to a clear address turns off exactly the mailbox bits that are 1 in the written word and leaves the other bits unchanged.
- R4: Interrupt line irq[k] is high exactly when mailbox k is nonzero. It changes in the cycle after the write that makes the mailbox nonzero or zero.
- R5: A read of either the set address or the clear address of a mailbox returns that mailbox's value on rd_data, with rd_valid high, one cycle after rd_en.
- R6: The set window starts at byte 0x80 and the clear window starts at byte 0xC0. Mailbox b of core c sits at window base + 16·c + 4·b, and its value drives irq[4·c + b].
- R7: A write to an address outside both windows, or to an address that is not word aligned, changes no mailbox. A read from such an address returns zero.
- R8: When a read and a write target the same mailbox in the same cycle, the read returns the value from before the write.
- R9: A full 32-bit word written to an empty mailbox through its set address is stored unchanged, every bit included.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Byte address of the write |
| wr_data | input | 32 | Write word; its 1 bits set or clear mailbox bits |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Byte address of the read |
| rd_data | output | 32 | Read result, one cycle after rd_en |
| rd_valid | output | 1 | High in the cycle rd_data holds a result |
| irq | output | 16 | Per-mailbox level interrupt, index 4·core + mailbox |

## Verification
A write takes effect at the clock edge where it is presented. The new mailbox value, and the interrupt level that follows from it, are visible one cycle later. A read result is also due one cycle after the request, and it reflects the mailbox contents from before any write presented at the same edge. The bench drives each operation on a falling edge and samples on the next falling edge. Before updating its model it computes the expected read word from the model's old state, so the same-cycle ordering of R8 is checked in every random step as well.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   // widest mailbox index any build may use
   localparam int unsigned MBX_IDX_W = 8;

   typedef struct packed {
      logic                 hit;     // address lands on a mailbox
      logic                 is_set;  // set window (1) or clear window (0)
      logic [MBX_IDX_W-1:0] idx;     // flat mailbox number core*per_core+box
   } mbx_dec_t;
endpackage

// File: rtl/mbx_addr_decode.sv
module mbx_addr_decode #(
   parameter int unsigned ADDR_W       = 8,
   parameter int unsigned NUM_CORES    = 4,
   parameter int unsigned BOX_PER_CORE = 4,
   parameter int unsigned SET_BASE     = 32'h80,
   parameter int unsigned CLR_BASE     = 32'hC0,
   parameter int unsigned CORE_STRIDE  = 16,
   parameter int unsigned BOX_STRIDE   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   output mbx_pkg::mbx_dec_t dec
);
   import mbx_pkg::*;

   localparam int unsigned NUM_BOX = NUM_CORES * BOX_PER_CORE;
   localparam int unsigned SPAN    = NUM_CORES * CORE_STRIDE;
   localparam int unsigned CS_SH   = $clog2(CORE_STRIDE);
   localparam int unsigned BS_SH   = $clog2(BOX_STRIDE);

   initial begin
      if (ADDR_W > 16)
         $error("mbx_addr_decode: ADDR_W must not exceed 16");
      if ((1 << CS_SH) != CORE_STRIDE || (1 << BS_SH) != BOX_STRIDE)
         $error("mbx_addr_decode: strides must be powers of two");
      if (BOX_PER_CORE * BOX_STRIDE > CORE_STRIDE)
         $error("mbx_addr_decode: mailboxes of one core overrun its stride");
      if (!((CLR_BASE >= SET_BASE + SPAN) || (SET_BASE >= CLR_BASE + SPAN)))
         $error("mbx_addr_decode: set and clear windows overlap");
      if (NUM_BOX > (1 << MBX_IDX_W))
         $error("mbx_addr_decode: too many mailboxes for index width");
      if (SET_BASE + SPAN > (1 << ADDR_W) || CLR_BASE + SPAN > (1 << ADDR_W))
         $error("mbx_addr_decode: window beyond address space");
   end

   function automatic mbx_dec_t win_dec(input int unsigned a,
                                        input int unsigned base,
                                        input logic set_win);
      mbx_dec_t    r;
      int unsigned off, core, rem, box;
      r = '0;
      if (a >= base && (a - base) < SPAN) begin
         off  = a - base;
         core = off >> CS_SH;
         rem  = off & (CORE_STRIDE - 1);
         box  = rem >> BS_SH;
         if ((rem & (BOX_STRIDE - 1)) == 0 && box < BOX_PER_CORE) begin
            r.hit    = 1'b1;
            r.is_set = set_win;
            r.idx    = MBX_IDX_W'(core * BOX_PER_CORE + box);
         end
      end
      return r;
   endfunction

   mbx_dec_t set_d, clr_d;
   int unsigned a_int;

   always_comb begin
      a_int = 32'(addr);
      set_d = win_dec(a_int, SET_BASE, 1'b1);
      clr_d = win_dec(a_int, CLR_BASE, 1'b0);
      dec   = set_d.hit ? set_d : clr_d;
   end

   // R6: a decoded hit always names an existing mailbox
   p_idx_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dec.hit |-> (32'(dec.idx) < NUM_BOX));
   // R7: the two windows never claim the same address
   p_win_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_d.hit && clr_d.hit));
endmodule

// File: rtl/mbx_cell.sv
module mbx_cell #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_we,
   input  logic              clr_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] value,
   output logic              irq
);
   initial begin
      if (DATA_W < 1 || DATA_W > 64)
         $error("mbx_cell: DATA_W out of range");
   end

   logic [DATA_W-1:0] set_mask, clr_mask, nxt;

   always_comb begin
      set_mask = set_we ? wdata : '0;
      clr_mask = clr_we ? wdata : '0;
      nxt      = (value | set_mask) & ~clr_mask;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) value <= '0;
      else        value <= nxt;
   end

   assign irq = |value;

   // R2: every bit rung by a set write is on afterwards
   p_set_or_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (set_we && !clr_we) |=> ((value & $past(wdata)) == $past(wdata)));
   // R3: every bit named by a clear write is off afterwards
   p_clr_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> ((value & $past(wdata)) == '0));
   // R3: bits not named by a clear write are kept
   p_clr_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && !set_we) |=> (value == ($past(value) & ~$past(wdata))));
   // R7: with no write the mailbox holds
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_we && !clr_we) |=> $stable(value));
   // R4: an interrupt can only rise after a set write
   p_irq_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(set_we));
endmodule

// File: rtl/mbx_rd_port.sv
module mbx_rd_port #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned NUM_BOX = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      rd_en,
   input  mbx_pkg::mbx_dec_t         dec,
   input  logic [NUM_BOX*DATA_W-1:0] values,
   output logic [DATA_W-1:0]         rd_data,
   output logic                      rd_valid
);
   import mbx_pkg::*;

   initial begin
      if (NUM_BOX < 1)
         $error("mbx_rd_port: need at least one mailbox");
   end

   logic [DATA_W-1:0] sel;

   always_comb begin
      sel = '0;
      for (int i = 0; i < NUM_BOX; i++) begin
         if (dec.hit && 32'(dec.idx) == i)
            sel = values[i*DATA_W +: DATA_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_en;
         rd_data  <= rd_en ? sel : '0;
      end
   end

   // R5: a result is due exactly one cycle after the request
   p_rd_lat_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);
   // R7: a read that decodes to nothing returns zero
   p_rd_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !dec.hit) |=> (rd_data == '0));
endmodule

// File: rtl/doorbell_mbox_array.sv
module doorbell_mbox_array #(
   parameter int unsigned ADDR_W       = 8,
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned NUM_CORES    = 4,
   parameter int unsigned BOX_PER_CORE = 4,
   parameter int unsigned SET_BASE     = 32'h80,
   parameter int unsigned CLR_BASE     = 32'hC0,
   parameter int unsigned CORE_STRIDE  = 16,
   parameter int unsigned BOX_STRIDE   = 4
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                wr_en,
   input  logic [ADDR_W-1:0]                   wr_addr,
   input  logic [DATA_W-1:0]                   wr_data,
   input  logic                                rd_en,
   input  logic [ADDR_W-1:0]                   rd_addr,
   output logic [DATA_W-1:0]                   rd_data,
   output logic                                rd_valid,
   output logic [NUM_CORES*BOX_PER_CORE-1:0]   irq
);
   import mbx_pkg::*;

   localparam int unsigned NUM_BOX = NUM_CORES * BOX_PER_CORE;

   initial begin
      if (NUM_CORES < 1 || BOX_PER_CORE < 1)
         $error("doorbell_mbox_array: need at least one mailbox");
   end

   mbx_dec_t wdec, rdec;
   logic [NUM_BOX*DATA_W-1:0] values;

   mbx_addr_decode #(
      .ADDR_W(ADDR_W), .NUM_CORES(NUM_CORES), .BOX_PER_CORE(BOX_PER_CORE),
      .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE),
      .CORE_STRIDE(CORE_STRIDE), .BOX_STRIDE(BOX_STRIDE)
   ) u_wdec (
      .clk(clk), .rst_n(rst_n), .addr(wr_addr), .dec(wdec)
   );

   mbx_addr_decode #(
      .ADDR_W(ADDR_W), .NUM_CORES(NUM_CORES), .BOX_PER_CORE(BOX_PER_CORE),
      .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE),
      .CORE_STRIDE(CORE_STRIDE), .BOX_STRIDE(BOX_STRIDE)
   ) u_rdec (
      .clk(clk), .rst_n(rst_n), .addr(rd_addr), .dec(rdec)
   );

   generate
      for (genvar g = 0; g < NUM_BOX; g++) begin : g_box
         logic sel_w;
         logic [DATA_W-1:0] val_g;
         assign sel_w = wr_en && wdec.hit && (32'(wdec.idx) == g);

         mbx_cell #(.DATA_W(DATA_W)) u_cell (
            .clk(clk), .rst_n(rst_n),
            .set_we(sel_w && wdec.is_set),
            .clr_we(sel_w && !wdec.is_set),
            .wdata(wr_data),
            .value(val_g),
            .irq(irq[g])
         );
         assign values[g*DATA_W +: DATA_W] = val_g;
      end
   endgenerate

   mbx_rd_port #(.DATA_W(DATA_W), .NUM_BOX(NUM_BOX)) u_rd (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .dec(rdec),
      .values(values), .rd_data(rd_data), .rd_valid(rd_valid)
   );

   // R7: a write that decodes to nothing leaves every line as it was
   p_miss_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || !wdec.hit) |=> $stable(irq));
   // R4: a write to one mailbox never moves any other line
   p_one_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ($countones(irq ^ $past(irq)) <= 1));
endmodule

// File: tb/doorbell_mbox_array_bench.sv
module doorbell_mbox_array_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NB = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [7:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        rd_valid;
   logic [15:0] irq;

   int checks = 0;
   int errors = 0;
   bit finished = 0;
   logic [31:0] model [NB];

   always #(CLK_PERIOD/2) clk = ~clk;

   doorbell_mbox_array u_doorbell_mbox_array (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(rd_data), .rd_valid(rd_valid), .irq(irq)
   );

   // requirement model of the address map (R6, R7)
   function automatic int box_of(input logic [7:0] a, output bit is_set);
      int v;
      v = int'(a);
      is_set = 0;
      if (v[1:0] != 2'b00) return -1;
      if (v >= 'h80 && v < 'hC0) begin is_set = 1; return (v - 'h80) >> 2; end
      if (v >= 'hC0 && v < 'h100) return (v - 'hC0) >> 2;
      return -1;
   endfunction

   function automatic logic [7:0] set_addr(input int core, input int box);
      return 8'('h80 + 16*core + 4*box);
   endfunction

   function automatic logic [7:0] clr_addr(input int core, input int box);
      return 8'('hC0 + 16*core + 4*box);
   endfunction

   function automatic logic [31:0] model_read(input logic [7:0] a);
      bit s;
      int k;
      k = box_of(a, s);
      return (k < 0) ? 32'h0 : model[k];
   endfunction

   function automatic logic [15:0] model_irq();
      logic [15:0] r;
      for (int i = 0; i < NB; i++) r[i] = (model[i] != 0);
      return r;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one bus cycle: drive on falling edge, check on next falling edge
   task automatic cyc(input string req, input bit we, input logic [7:0] wa,
                      input logic [31:0] wd, input bit re, input logic [7:0] ra);
      logic [31:0] exp_rd;
      bit s;
      int k;
      wr_en = we; wr_addr = wa; wr_data = wd;
      rd_en = re; rd_addr = ra;
      exp_rd = model_read(ra);          // pre-write value (R8)
      if (we) begin
         k = box_of(wa, s);
         if (k >= 0) model[k] = s ? (model[k] | wd) : (model[k] & ~wd);
      end
      @(negedge clk);
      wr_en = 0; rd_en = 0;
      chk({req, " rd_valid"}, 32'(rd_valid), 32'(re));
      if (re) chk({req, " rd_data"}, rd_data, exp_rd);
      chk({req, " irq"}, 32'(irq), 32'(model_irq()));
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual=running expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < NB; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 irq", 32'(irq), 32'h0);
      chk("R1 rd_valid", 32'(rd_valid), 32'h0);
      cyc("R1 read", 0, 0, 0, 1, clr_addr(3, 2));

      // R2: OR semantics, R4 rise
      cyc("R2 first", 1, set_addr(1, 0), 32'h20, 0, 0);
      cyc("R2 second", 1, set_addr(1, 0), 32'h200, 1, clr_addr(1, 0));
      cyc("R2 readback", 0, 0, 0, 1, set_addr(1, 0));
      // R3: clear of one bit keeps the other
      cyc("R3 clear one", 1, clr_addr(1, 0), 32'h20, 0, 0);
      cyc("R3 readback", 0, 0, 0, 1, clr_addr(1, 0));
      // R4: last bit cleared drops the line
      cyc("R4 clear last", 1, clr_addr(1, 0), 32'h200, 0, 0);
      chk("R4 line low", 32'(irq[4]), 32'h0);

      // R9: full word into core 2 mailbox 3
      cyc("R9 write", 1, set_addr(2, 3), 32'h8000_0041, 0, 0);
      cyc("R9 read", 0, 0, 0, 1, clr_addr(2, 3));
      chk("R9 line", 32'(irq[11]), 32'h1);

      // R8: read and write same mailbox same cycle
      cyc("R8 same cycle", 1, set_addr(0, 1), 32'h0000_0F00, 1, set_addr(0, 1));
      cyc("R8 after", 0, 0, 0, 1, set_addr(0, 1));

      // R7: misaligned and unmapped accesses change nothing, read zero
      cyc("R7 misaligned w", 1, 8'h82, 32'hFFFF_FFFF, 1, 8'hC6);
      cyc("R7 unmapped w", 1, 8'h7C, 32'hFFFF_FFFF, 1, 8'h04);
      cyc("R7 unmapped w2", 1, 8'h00, 32'hFFFF_FFFF, 1, 8'h7C);
      cyc("R7 intact", 0, 0, 0, 1, clr_addr(2, 3));

      // R6: every mailbox maps to its own line and address
      for (int c = 0; c < 4; c++)
         for (int b = 0; b < 4; b++)
            cyc("R6 set each", 1, set_addr(c, b), 32'(c*4 + b + 1) << 4, 1, clr_addr(c, b));
      for (int c = 0; c < 4; c++)
         for (int b = 0; b < 4; b++)
            cyc("R6 read each", 0, 0, 0, 1, set_addr(c, b));
      for (int i = 0; i < NB; i++) begin
         cyc("R6 clear each", 1, clr_addr(i / 4, i % 4), 32'hFFFF_FFFF, 0, 0);
         chk("R6 line off", 32'(irq[i]), 32'h0);
      end

      // random mix (R2, R3, R4, R5, R7, R8)
      for (int n = 0; n < 1500; n++) begin
         logic [7:0]  wa, ra;
         logic [31:0] wd;
         int mode;
         mode = int'($urandom_range(0, 5));
         case (mode)
            0, 1: wa = set_addr(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)));
            2, 3: wa = clr_addr(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)));
            default: wa = 8'($urandom);
         endcase
         ra = ($urandom_range(0, 3) == 0) ? 8'($urandom)
              : 8'('h80 + 4 * $urandom_range(0, 31));
         wd = ($urandom_range(0, 1) == 0) ? (32'h1 << $urandom_range(0, 31)) : $urandom;
         cyc("R5 random", $urandom_range(0, 3) != 0, wa, wd, $urandom_range(0, 1) == 1, ra);
      end

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule